// File: doc/BRIEF.md
# Mode-Switched Two-Lane Adder

This block adds two 64-bit operands using two 32-bit lane adders, a low lane and a high lane. A single mode input decides whether the carry produced by the low lane reaches the high lane. With the mode bit clear, the block behaves as two independent 32-bit adders side by side. Each half of the result wraps modulo 2^32 and nothing crosses the lane boundary. With the mode bit set, the low lane's carry-out drives the high lane's carry-in, and the pair forms one 64-bit ripple-connected adder that wraps modulo 2^64.

The block is purely combinational. A datapath that sometimes processes one wide word and sometimes two narrow words can share one adder and pick the behaviour per operation. No carry leaves the block in either mode.

Top module: `dual_lane_adder`

## Requirements
- R1: The low 32 bits of `sum` always equal (`op_a[31:0]` + `op_b[31:0]`) modulo 2^32, whatever the value of `dword`.
- R2: With `dword` = 0 (split), `sum[63:32]` equals (`op_a[63:32]` + `op_b[63:32]`) modulo 2^32, and no carry from the low lane reaches the high lane.
- R3: With `dword` = 1 (joined), `sum` equals (`op_a` + `op_b`) modulo 2^64.
- R4: At the lane boundary, low operands 0xFFFFFFFF and 0x00000001 with zero high operands give `sum` = 0x0000000000000000 in split mode and 0x0000000100000000 in joined mode.
- R5: No carry-out leaves the block. In joined mode all-ones plus one gives zero, and in split mode all-ones plus one in both lanes gives zero.
- R6: The output is combinational. With the operands held, toggling `dword` changes `sum[63:32]` in the same cycle by exactly the low lane's carry, and leaves `sum[31:0]` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand; bits 31:0 feed the low lane and bits 63:32 feed the high lane |
| op_b | input | 64 | Second operand, split across the lanes in the same way |
| dword | input | 1 | Mode select: 0 gives two independent 32-bit lanes, 1 gives one 64-bit add |
| sum | output | 64 | Sum, modulo 2^32 per lane or modulo 2^64 as a whole |

## Verification
The assertions are immediate checks on settled combinational values. They assume every input bit is driven to 0 or 1 and never left unknown. The bench starts all inputs at defined zero values before time advances and changes them only one clock phase before each comparison, so every check sees settled logic. The stimulus covers both modes on the same operand pairs and drives carries that reach exactly bit 31 and bit 63.

// File: rtl/dual_lane_adder_pkg.sv
package dual_lane_adder_pkg;

  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_JOINED = 1'b1
  } lane_mode_e;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] bit_add(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

  // Carry passed to the high lane for a given mode.
  function automatic logic link_carry(input lane_mode_e m, input logic low_co);
    return (m == MODE_JOINED) ? low_co : 1'b0;
  endfunction

endpackage

// File: rtl/lane_adder.sv
module lane_adder #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] x,
  input  logic [LANE_W-1:0] y,
  input  logic              ci,
  output logic [LANE_W-1:0] s,
  output logic              co
);
  import dual_lane_adder_pkg::*;

  always_comb begin
    logic       c;
    logic [1:0] r;
    c = ci;
    s = '0;
    for (int i = 0; i < LANE_W; i++) begin
      r    = bit_add(x[i], y[i], c);
      s[i] = r[0];
      c    = r[1];
    end
    co = c;
  end
endmodule

// File: rtl/carry_link.sv
module carry_link (
  input  logic mode,
  input  logic low_co,
  output logic high_ci
);
  import dual_lane_adder_pkg::*;

  lane_mode_e m;
  assign m       = lane_mode_e'(mode);
  assign high_ci = link_carry(m, low_co);
endmodule

// File: rtl/dual_lane_adder.sv
module dual_lane_adder #(
  parameter int LANE_W = 32,
  localparam int WIDE_W = 2 * LANE_W
) (
  input  logic [WIDE_W-1:0] op_a,
  input  logic [WIDE_W-1:0] op_b,
  input  logic              dword,
  output logic [WIDE_W-1:0] sum
);
  // Internal events brought out by name for the checker.
  logic low_co;
  logic high_ci;
  logic high_co;

  lane_adder #(.LANE_W(LANE_W)) u_low (
    .x (op_a[LANE_W-1:0]),
    .y (op_b[LANE_W-1:0]),
    .ci(1'b0),
    .s (sum[LANE_W-1:0]),
    .co(low_co)
  );

  carry_link u_link (
    .mode   (dword),
    .low_co (low_co),
    .high_ci(high_ci)
  );

  lane_adder #(.LANE_W(LANE_W)) u_high (
    .x (op_a[WIDE_W-1:LANE_W]),
    .y (op_b[WIDE_W-1:LANE_W]),
    .ci(high_ci),
    .s (sum[WIDE_W-1:LANE_W]),
    .co(high_co)
  );

  // The top carry is dropped: the result wraps.
  logic unused_high_co;
  assign unused_high_co = high_co;
endmodule

// File: rtl/dual_lane_adder_chk.sv
module dual_lane_adder_chk #(
  parameter int LANE_W = 32,
  localparam int WIDE_W = 2 * LANE_W
) (
  input logic [WIDE_W-1:0] op_a,
  input logic [WIDE_W-1:0] op_b,
  input logic              dword,
  input logic [WIDE_W-1:0] sum,
  input logic              low_co,
  input logic              high_ci
);
  logic [LANE_W:0]   lo_full;
  logic [LANE_W:0]   hi_full;
  logic [WIDE_W:0]   wide_full;

  always_comb begin
    lo_full   = {1'b0, op_a[LANE_W-1:0]} + {1'b0, op_b[LANE_W-1:0]};
    hi_full   = {1'b0, op_a[WIDE_W-1:LANE_W]} + {1'b0, op_b[WIDE_W-1:LANE_W]};
    wide_full = {1'b0, op_a} + {1'b0, op_b};

    // R1
    low_lane_chk: assert (sum[LANE_W-1:0] == lo_full[LANE_W-1:0]);
    // R6
    low_carry_chk: assert (low_co == lo_full[LANE_W]);
    // R2
    split_isolation_chk: assert (dword || (high_ci == 1'b0 && sum[WIDE_W-1:LANE_W] == hi_full[LANE_W-1:0]));
    // R3
    joined_link_chk: assert (!dword || high_ci == low_co);
    // R3
    joined_sum_chk: assert (!dword || sum == wide_full[WIDE_W-1:0]);
  end
endmodule

bind dual_lane_adder dual_lane_adder_chk #(.LANE_W(LANE_W)) u_chk (
  .op_a   (op_a),
  .op_b   (op_b),
  .dword  (dword),
  .sum    (sum),
  .low_co (low_co),
  .high_ci(high_ci)
);

// File: tb/dual_lane_adder_test.sv
module dual_lane_adder_test;
  logic        clk = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dword = 1'b0;
  logic [63:0] sum;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  dual_lane_adder uut (
    .op_a (op_a),
    .op_b (op_b),
    .dword(dword),
    .sum  (sum)
  );

  // Behavioural reference: plain integer arithmetic per mode.
  function automatic longint unsigned model(longint unsigned a, longint unsigned b, bit m);
    longint unsigned lo, hi;
    if (m) return a + b;
    lo = ((a & 64'hFFFF_FFFF) + (b & 64'hFFFF_FFFF)) & 64'hFFFF_FFFF;
    hi = ((a >> 32) + (b >> 32)) & 64'hFFFF_FFFF;
    return (hi << 32) | lo;
  endfunction

  task automatic compare(string req, logic [63:0] exp);
    vectors++;
    if (sum !== exp) begin
      miscompares++;
      $display("FAIL %s a=%h b=%h dword=%0d got=%h exp=%h", req, op_a, op_b, dword, sum, exp);
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply(string req, logic [63:0] a, logic [63:0] b, bit m);
    @(posedge clk);
    op_a = a; op_b = b; dword = m;
    @(negedge clk);
    compare(req, model(a, b, m));
  endtask

  task automatic apply_exp(string req, logic [63:0] a, logic [63:0] b, bit m, logic [63:0] exp);
    @(posedge clk);
    op_a = a; op_b = b; dword = m;
    @(negedge clk);
    compare(req, exp);
  endtask

  initial begin
    // Reset state: all inputs zero gives zero
    @(negedge clk);
    compare("R1 reset", 64'h0);

    // R4 boundary at bit 31
    apply_exp("R4 split", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 64'h0);
    apply_exp("R4 joined", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 64'h0000_0001_0000_0000);
    // R5 no carry out
    apply_exp("R5 joined wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 64'h0);
    apply_exp("R5 split wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, 64'h0);
    // R2 high lane independent of low carry
    apply_exp("R2 split", 64'h1234_5678_8000_0000, 64'h1111_1111_8000_0000, 1'b0, 64'h2345_6789_0000_0000);
    // R3 long carry ripple
    apply_exp("R3 joined", 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 64'h0001_0000_0000_0000);

    // R6 toggle mode with fixed operands, observed in the same cycle
    @(posedge clk);
    op_a = 64'h0000_0005_F000_0000; op_b = 64'h0000_0003_2000_0000; dword = 1'b0;
    @(negedge clk);
    compare("R6 split", 64'h0000_0008_1000_0000);
    dword = 1'b1;
    #1;
    compare("R6 joined same cycle", 64'h0000_0009_1000_0000);

    // R1 R2 R3 random sweep, both modes on each pair
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 0) b[31:0] = ~a[31:0] + 32'd1;
      apply("R2 sweep", a, b, 1'b0);
      apply("R3 sweep", a, b, 1'b1);
      if (sum[31:0] !== a[31:0] + b[31:0]) begin
        miscompares++;
        $display("FAIL R1 low lane got=%h exp=%h", sum[31:0], a[31:0] + b[31:0]);
      end
      vectors++;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule